// File: doc/BRIEF.md
# Infrared MAC Frame Header Filter

This block sits above the symbol decoder of a polled infrared link. It takes one frame at a time as a byte stream, with start and end markers and a flag that says whether the frame was delimited as short or long. The CRC has already been checked below it. The first byte of a frame is the host address. In the second byte, the upper nibble is the MAC control field and the lower nibble is the peripheral address. All bytes after that are payload.

The filter can be set up for either end of the link.
- **Host side:** it receives frames sent by peripherals.
- **Peripheral side:** it receives frames sent by a host.

In both cases it checks the direction bit, the addresses, the reserved control bits, the long-frame permission and the payload length against the local configuration. When the header passes, it pulses the decoded control flags. While the frame stays good, it forwards payload bytes one cycle after they arrive. At the end of every frame it gives one verdict pulse, either accept or drop with a reason code.

The payload is forwarded before the final verdict is known. The consumer therefore holds the bytes of a frame until the verdict pulse and discards them on a drop. Configuration inputs must be held stable while a frame is in progress.

Top module: `mac_hdr_filter`

## Requirements
- R1: After reset, `pay_valid`, `hdr_valid` and `done_valid` are low, and they stay low until frame bytes arrive.
- R2: Direction check on control bit 7 (bit 3 of the upper nibble of byte 1):
  - Host side requires 0.
  - Peripheral side requires 1.
  - Otherwise the frame is dropped with reason 1.
- R3: Host-side address check:
  - Byte 0 must equal `cfg_own_hadd`, or be 0x00 while `cfg_asleep` is 1.
  - The peripheral address is not checked.
  - Otherwise the frame is dropped with reason 2.
- R4: Peripheral-side address check. The peripheral address (byte 1 bits 3:0) is accepted in exactly three cases:
  - it is 0xF while `cfg_enumerated` is 0, with any host address;
  - it is 0x0 while enumerated and not `cfg_bound`, with the host address matching;
  - it equals `cfg_own_padd` while bound, with the host address matching.
  - Otherwise the frame is dropped with reason 2.
- R5: On the host side, control bits 5 and 4 (byte 1 bits 5:4) must be 0. Otherwise the frame is dropped with reason 3.
- R6: Payload length limits:
  - A frame flagged short may carry 0 to SHORT_MAX (9) payload bytes.
  - A frame flagged long may carry 0 to LONG_MAX (97) payload bytes.
  - The first byte beyond the limit sets reason 4 and is not forwarded, and neither is any byte after it.
- R7: A frame flagged long while `cfg_long_allow` is 0 is dropped with reason 5.
- R8: A frame that ends on its first byte is dropped with reason 6.
- R9: When several faults apply, the reported reason is the first one in this order: 6, 1, 2, 3, 5, 4. `done_ok` is 1 exactly when the reason is 0.
- R10: Output timing:
  - A payload byte appears on `pay_data` with `pay_valid` on the cycle after it is presented.
  - `done_valid` pulses on the cycle after the end byte.
  - `hdr_valid` pulses on the cycle after byte 1, and only if the header passes.
- R11: Flag decoding:
  - On the host side, `hdr_poll_req` is control bit 6.
  - On the peripheral side, `hdr_bind_restart`, `hdr_long_en` and `hdr_hail` are control bits 6, 5 and 4.
  - Flags that do not belong to the side in use read 0.
- R12: Bytes presented outside a frame are ignored. A start marker in the middle of a frame abandons that frame without a verdict and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_host_side | input | 1 | 1: receive peripheral frames; 0: receive host frames |
| cfg_own_hadd | input | 8 | Local or stored host address |
| cfg_own_padd | input | 4 | Assigned peripheral address |
| cfg_asleep | input | 1 | Host is sleeping; accept broadcast host address 0x00 |
| cfg_bound | input | 1 | Peripheral holds an assigned address |
| cfg_enumerated | input | 1 | Peripheral is known to a host |
| cfg_long_allow | input | 1 | Long frames are permitted |
| in_valid | input | 1 | Byte strobe |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_long | input | 1 | Frame delimited as long (sampled with the first byte) |
| in_data | input | 8 | Frame byte |
| pay_valid | output | 1 | Payload byte strobe |
| pay_data | output | 8 | Payload byte |
| hdr_valid | output | 1 | Header accepted pulse |
| hdr_hadd | output | 8 | Received host address |
| hdr_padd | output | 4 | Received peripheral address |
| hdr_bind_restart | output | 1 | Bind timer restarted flag (host frames) |
| hdr_long_en | output | 1 | Long frame enable flag (host frames) |
| hdr_hail | output | 1 | Device hailing flag (host frames) |
| hdr_poll_req | output | 1 | Polling request flag (peripheral frames) |
| done_valid | output | 1 | End-of-frame verdict pulse |
| done_ok | output | 1 | Frame accepted |
| done_reason | output | 3 | 0 ok, 1 direction, 2 address, 3 reserved bits, 4 too long, 5 long not allowed, 6 runt |

## Verification
The checker watches several properties on every cycle:
- A payload pulse never follows a start byte.
- The per-frame payload count never exceeds the limit for the frame's delimiter type.
- An accepted header always had the expected direction bit, clear reserved bits on the host side, and long permission if it was flagged long.
- Decoded flags never leak across sides.
- Every one-byte frame ends as a runt.

Only the bench's scenarios can show the following:
- the priority among overlapping faults;
- the three-way peripheral addressing rule and the sleeping-host broadcast case;
- the exact byte on which the length limit starts to drop data;
- that a restarted frame yields a single verdict.

// File: rtl/hdrf_pkg.sv
package hdrf_pkg;

    localparam int HADD_W = 8;
    localparam int PADD_W = 4;

    localparam logic [PADD_W-1:0] PADD_BIND  = 4'h0;
    localparam logic [PADD_W-1:0] PADD_ENUM  = 4'hF;
    localparam logic [HADD_W-1:0] HADD_BCAST = 8'h00;

    typedef enum logic [2:0] {
        RSN_NONE = 3'd0,
        RSN_DIR  = 3'd1,
        RSN_ADDR = 3'd2,
        RSN_RSVD = 3'd3,
        RSN_LEN  = 3'd4,
        RSN_LONG = 3'd5,
        RSN_RUNT = 3'd6
    } reason_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY  = 2'd2
    } state_e;

endpackage

// File: rtl/hdrf_addr_match.sv
module hdrf_addr_match
    import hdrf_pkg::*;
(
    input  logic              host_side,
    input  logic [HADD_W-1:0] own_hadd,
    input  logic [PADD_W-1:0] own_padd,
    input  logic              asleep,
    input  logic              bound,
    input  logic              enumerated,
    input  logic [HADD_W-1:0] rx_hadd,
    input  logic [PADD_W-1:0] rx_padd,
    output logic              match
);

    logic hadd_eq;
    logic own_is_rsvd;
    logic hit_enum;
    logic hit_bind;
    logic hit_own;

    always_comb begin
        hadd_eq     = (rx_hadd == own_hadd);
        own_is_rsvd = (own_padd == PADD_BIND) || (own_padd == PADD_ENUM);
        hit_enum    = (rx_padd == PADD_ENUM) && !enumerated;
        hit_bind    = (rx_padd == PADD_BIND) && enumerated && !bound && hadd_eq;
        hit_own     = bound && !own_is_rsvd && (rx_padd == own_padd) && hadd_eq;
        if (host_side) begin
            match = hadd_eq || ((rx_hadd == HADD_BCAST) && asleep);
        end else begin
            match = hit_enum || hit_bind || hit_own;
        end
    end

endmodule

// File: rtl/hdrf_ctrl_check.sv
module hdrf_ctrl_check (
    input  logic       host_side,
    input  logic [3:0] ctl,
    input  logic       rx_long,
    input  logic       long_allow,
    output logic       dir_bad,
    output logic       rsvd_bad,
    output logic       long_bad,
    output logic       f_bind_restart,
    output logic       f_long_en,
    output logic       f_hail,
    output logic       f_poll_req
);

    always_comb begin
        dir_bad        = (ctl[3] == host_side);
        rsvd_bad       = host_side && (ctl[1:0] != 2'b00);
        long_bad       = rx_long && !long_allow;
        f_poll_req     = host_side  && ctl[2];
        f_bind_restart = !host_side && ctl[2];
        f_long_en      = !host_side && ctl[1];
        f_hail         = !host_side && ctl[0];
    end

endmodule

// File: rtl/hdrf_len_limit.sv
module hdrf_len_limit #(
    parameter int SHORT_MAX = 9,
    parameter int LONG_MAX  = 97,
    parameter int CNT_W     = 7
) (
    input  logic             is_long,
    input  logic [CNT_W-1:0] cnt,
    output logic             at_limit
);

    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_MAX);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_MAX);

    always_comb begin
        at_limit = (cnt == (is_long ? LONG_LIM : SHORT_LIM));
    end

endmodule

// File: rtl/mac_hdr_filter.sv
module mac_hdr_filter
    import hdrf_pkg::*;
#(
    parameter int SHORT_MAX = 9,
    parameter int LONG_MAX  = 97
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_host_side,
    input  logic [7:0] cfg_own_hadd,
    input  logic [3:0] cfg_own_padd,
    input  logic       cfg_asleep,
    input  logic       cfg_bound,
    input  logic       cfg_enumerated,
    input  logic       cfg_long_allow,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic       in_eop,
    input  logic       in_long,
    input  logic [7:0] in_data,
    output logic       pay_valid,
    output logic [7:0] pay_data,
    output logic       hdr_valid,
    output logic [7:0] hdr_hadd,
    output logic [3:0] hdr_padd,
    output logic       hdr_bind_restart,
    output logic       hdr_long_en,
    output logic       hdr_hail,
    output logic       hdr_poll_req,
    output logic       done_valid,
    output logic       done_ok,
    output logic [2:0] done_reason
);

    localparam int CNT_W = $clog2(LONG_MAX + 1);

    typedef struct packed {
        state_e             st;
        logic [HADD_W-1:0]  hadd;
        logic               is_long;
        reason_e            rsn;
        logic [CNT_W-1:0]   cnt;
        logic               pay_v;
        logic [7:0]         pay_d;
        logic               hdr_v;
        logic [HADD_W-1:0]  hdr_hadd;
        logic [PADD_W-1:0]  hdr_padd;
        logic               f_bind;
        logic               f_longen;
        logic               f_hail;
        logic               f_poll;
        logic               done_v;
        logic               done_ok;
        reason_e            done_rsn;
    } regs_t;

    localparam regs_t REGS_RST = '0;

    regs_t q, d;

    logic    addr_ok;
    logic    dir_bad, rsvd_bad, long_bad;
    logic    c_bind, c_longen, c_hail, c_poll;
    logic    at_limit;
    reason_e hdr_rsn;

    hdrf_addr_match u_addr (
        .host_side  (cfg_host_side),
        .own_hadd   (cfg_own_hadd),
        .own_padd   (cfg_own_padd),
        .asleep     (cfg_asleep),
        .bound      (cfg_bound),
        .enumerated (cfg_enumerated),
        .rx_hadd    (q.hadd),
        .rx_padd    (in_data[3:0]),
        .match      (addr_ok)
    );

    hdrf_ctrl_check u_ctrl (
        .host_side      (cfg_host_side),
        .ctl            (in_data[7:4]),
        .rx_long        (q.is_long),
        .long_allow     (cfg_long_allow),
        .dir_bad        (dir_bad),
        .rsvd_bad       (rsvd_bad),
        .long_bad       (long_bad),
        .f_bind_restart (c_bind),
        .f_long_en      (c_longen),
        .f_hail         (c_hail),
        .f_poll_req     (c_poll)
    );

    hdrf_len_limit #(
        .SHORT_MAX (SHORT_MAX),
        .LONG_MAX  (LONG_MAX),
        .CNT_W     (CNT_W)
    ) u_len (
        .is_long  (q.is_long),
        .cnt      (q.cnt),
        .at_limit (at_limit)
    );

    // Fault priority for the header byte
    always_comb begin
        if (dir_bad) begin
            hdr_rsn = RSN_DIR;
        end else if (!addr_ok) begin
            hdr_rsn = RSN_ADDR;
        end else if (rsvd_bad) begin
            hdr_rsn = RSN_RSVD;
        end else if (long_bad) begin
            hdr_rsn = RSN_LONG;
        end else begin
            hdr_rsn = RSN_NONE;
        end
    end

    always_comb begin
        d        = q;
        d.pay_v  = 1'b0;
        d.hdr_v  = 1'b0;
        d.done_v = 1'b0;
        if (in_valid) begin
            if (in_sop) begin
                d.st      = ST_HDR;
                d.hadd    = in_data;
                d.is_long = in_long;
                d.rsn     = RSN_NONE;
                d.cnt     = '0;
                if (in_eop) begin
                    d.st       = ST_IDLE;
                    d.done_v   = 1'b1;
                    d.done_ok  = 1'b0;
                    d.done_rsn = RSN_RUNT;
                end
            end else begin
                case (q.st)
                    ST_HDR: begin
                        d.st  = ST_PAY;
                        d.rsn = hdr_rsn;
                        if (hdr_rsn == RSN_NONE) begin
                            d.hdr_v    = 1'b1;
                            d.hdr_hadd = q.hadd;
                            d.hdr_padd = in_data[3:0];
                            d.f_bind   = c_bind;
                            d.f_longen = c_longen;
                            d.f_hail   = c_hail;
                            d.f_poll   = c_poll;
                        end
                    end
                    ST_PAY: begin
                        if (q.rsn == RSN_NONE) begin
                            if (at_limit) begin
                                d.rsn = RSN_LEN;
                            end else begin
                                d.pay_v = 1'b1;
                                d.pay_d = in_data;
                                d.cnt   = q.cnt + CNT_W'(1);
                            end
                        end
                    end
                    default: begin
                    end
                endcase
                if (in_eop && (q.st != ST_IDLE)) begin
                    d.st       = ST_IDLE;
                    d.done_v   = 1'b1;
                    d.done_ok  = (d.rsn == RSN_NONE);
                    d.done_rsn = d.rsn;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= REGS_RST;
        end else begin
            q <= d;
        end
    end

    assign pay_valid        = q.pay_v;
    assign pay_data         = q.pay_d;
    assign hdr_valid        = q.hdr_v;
    assign hdr_hadd         = q.hdr_hadd;
    assign hdr_padd         = q.hdr_padd;
    assign hdr_bind_restart = q.f_bind;
    assign hdr_long_en      = q.f_longen;
    assign hdr_hail         = q.f_hail;
    assign hdr_poll_req     = q.f_poll;
    assign done_valid       = q.done_v;
    assign done_ok          = q.done_ok;
    assign done_reason      = q.done_rsn;

endmodule

// File: rtl/hdrf_chk.sv
module hdrf_chk #(
    parameter int SHORT_MAX = 9,
    parameter int LONG_MAX  = 97
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_host_side,
    input logic       cfg_long_allow,
    input logic       in_valid,
    input logic       in_sop,
    input logic       in_eop,
    input logic       in_long,
    input logic [7:0] in_data,
    input logic       pay_valid,
    input logic       hdr_valid,
    input logic       hdr_bind_restart,
    input logic       hdr_long_en,
    input logic       hdr_hail,
    input logic       hdr_poll_req,
    input logic       done_valid,
    input logic       done_ok,
    input logic [2:0] done_reason
);

    localparam int PC_W = $clog2(LONG_MAX + 2);

    logic [PC_W-1:0] pcnt;
    logic            long_cap;
    logic [PC_W-1:0] plim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt     <= '0;
            long_cap <= 1'b0;
        end else if (in_valid && in_sop) begin
            pcnt     <= '0;
            long_cap <= in_long;
        end else if (pay_valid) begin
            pcnt     <= pcnt + PC_W'(1);
        end
    end

    assign plim = long_cap ? PC_W'(LONG_MAX) : PC_W'(SHORT_MAX);

    AST_PAY_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> (pcnt < plim)); // R6

    AST_HDR_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> ($past(in_data[7]) != cfg_host_side)); // R2

    AST_HDR_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && cfg_host_side) |-> ($past(in_data[5:4]) == 2'b00)); // R5

    AST_HDR_LONG_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> !(long_cap && !cfg_long_allow)); // R7

    AST_PAY_NOT_AFTER_SOP: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> ($past(in_valid) && !$past(in_sop))); // R10

    AST_FLAGS_HOST_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && cfg_host_side) |-> !(hdr_bind_restart || hdr_long_en || hdr_hail)); // R11

    AST_FLAGS_PERIPH_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !cfg_host_side) |-> !hdr_poll_req); // R11

    AST_RUNT_REASON: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && $past(in_valid && in_sop && in_eop)) |-> (done_reason == 3'd6)); // R8

    AST_OK_MEANS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_ok == (done_reason == 3'd0))); // R9

endmodule

bind mac_hdr_filter hdrf_chk #(
    .SHORT_MAX (SHORT_MAX),
    .LONG_MAX  (LONG_MAX)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_host_side    (cfg_host_side),
    .cfg_long_allow   (cfg_long_allow),
    .in_valid         (in_valid),
    .in_sop           (in_sop),
    .in_eop           (in_eop),
    .in_long          (in_long),
    .in_data          (in_data),
    .pay_valid        (pay_valid),
    .hdr_valid        (hdr_valid),
    .hdr_bind_restart (hdr_bind_restart),
    .hdr_long_en      (hdr_long_en),
    .hdr_hail         (hdr_hail),
    .hdr_poll_req     (hdr_poll_req),
    .done_valid       (done_valid),
    .done_ok          (done_ok),
    .done_reason      (done_reason)
);

// File: tb/tb_mac_hdr_filter.sv
`timescale 1ns/1ps
module tb_mac_hdr_filter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_host_side = 1'b1;
    logic [7:0] cfg_own_hadd = 8'h5A;
    logic [3:0] cfg_own_padd = 4'h3;
    logic       cfg_asleep = 1'b0;
    logic       cfg_bound = 1'b0;
    logic       cfg_enumerated = 1'b0;
    logic       cfg_long_allow = 1'b0;
    logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_long = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       pay_valid, hdr_valid, done_valid, done_ok;
    logic [7:0] pay_data, hdr_hadd;
    logic [3:0] hdr_padd;
    logic       hdr_bind_restart, hdr_long_en, hdr_hail, hdr_poll_req;
    logic [2:0] done_reason;

    int tests = 0;
    int fails = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    mac_hdr_filter dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_host_side(cfg_host_side), .cfg_own_hadd(cfg_own_hadd),
        .cfg_own_padd(cfg_own_padd), .cfg_asleep(cfg_asleep),
        .cfg_bound(cfg_bound), .cfg_enumerated(cfg_enumerated),
        .cfg_long_allow(cfg_long_allow),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_long(in_long), .in_data(in_data),
        .pay_valid(pay_valid), .pay_data(pay_data),
        .hdr_valid(hdr_valid), .hdr_hadd(hdr_hadd), .hdr_padd(hdr_padd),
        .hdr_bind_restart(hdr_bind_restart), .hdr_long_en(hdr_long_en),
        .hdr_hail(hdr_hail), .hdr_poll_req(hdr_poll_req),
        .done_valid(done_valid), .done_ok(done_ok), .done_reason(done_reason)
    );

    task automatic check(input bit cond, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: first fault of a header, by the requirement order
    function automatic int ref_header(bit host, int hadd, int b1, bit lng);
        int ctl, padd;
        bit addr_ok;
        ctl  = (b1 >> 4) & 15;
        padd = b1 & 15;
        if (((ctl >> 3) & 1) != (host ? 0 : 1)) return 1;
        if (host) addr_ok = (hadd == int'(cfg_own_hadd)) || (hadd == 0 && cfg_asleep);
        else if (padd == 15) addr_ok = !cfg_enumerated;
        else if (padd == 0) addr_ok = cfg_enumerated && !cfg_bound && hadd == int'(cfg_own_hadd);
        else addr_ok = cfg_bound && padd == int'(cfg_own_padd) && hadd == int'(cfg_own_hadd);
        if (!addr_ok) return 2;
        if (host && (ctl & 3) != 0) return 3;
        if (lng && !cfg_long_allow) return 5;
        return 0;
    endfunction

    // Model state and predicted outputs
    bit m_in = 0; int m_idx = 0; int m_hadd = 0; bit m_long = 0; int m_rsn = 0; int m_cnt = 0;
    bit e_pay = 0, e_hdr = 0, e_done = 0;
    int e_pay_d = 0, e_hadd = 0, e_padd = 0, e_ok = 0, e_rsn = 0;
    int e_bind = 0, e_len = 0, e_hail = 0, e_poll = 0;

    always @(posedge clk) begin
        e_pay = 0; e_hdr = 0; e_done = 0;
        if (!rst_n) begin
            m_in = 0; m_idx = 0;
        end else if (in_valid) begin
            if (in_sop) begin
                m_in = 1; m_idx = 1; m_hadd = in_data; m_long = in_long;
                m_rsn = 0; m_cnt = 0;
                if (in_eop) begin
                    m_in = 0; e_done = 1; e_ok = 0; e_rsn = 6;
                end
            end else if (m_in) begin
                m_idx++;
                if (m_idx == 2) begin
                    m_rsn = ref_header(cfg_host_side, m_hadd, in_data, m_long);
                    if (m_rsn == 0) begin
                        e_hdr = 1; e_hadd = m_hadd; e_padd = in_data & 15;
                        e_poll = cfg_host_side ? in_data[6] : 0;
                        e_bind = cfg_host_side ? 0 : in_data[6];
                        e_len  = cfg_host_side ? 0 : in_data[5];
                        e_hail = cfg_host_side ? 0 : in_data[4];
                    end
                end else if (m_rsn == 0) begin
                    if (m_cnt >= (m_long ? 97 : 9)) m_rsn = 4;
                    else begin e_pay = 1; e_pay_d = in_data; m_cnt++; end
                end
                if (in_eop) begin
                    m_in = 0; e_done = 1; e_ok = (m_rsn == 0); e_rsn = m_rsn;
                end
            end
        end
    end

    // Per-cycle comparison and frame monitor
    int mon_done = 0, mon_rsn = -1, mon_ok = -1, mon_pay = 0, mon_hdr = 0;
    int mon_poll = 0, mon_bind = 0, mon_len = 0, mon_hail = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            check(pay_valid == e_pay && hdr_valid == e_hdr && done_valid == e_done,
                  cur_tag, "strobes {pay,hdr,done}",
                  {pay_valid, hdr_valid, done_valid}, {e_pay, e_hdr, e_done});
            if (e_pay && pay_valid)
                check(int'(pay_data) == e_pay_d, cur_tag, "pay_data", pay_data, e_pay_d);
            if (e_hdr && hdr_valid)
                check(int'(hdr_hadd) == e_hadd && int'(hdr_padd) == e_padd &&
                      int'({hdr_bind_restart, hdr_long_en, hdr_hail, hdr_poll_req}) ==
                      ((e_bind << 3) | (e_len << 2) | (e_hail << 1) | e_poll),
                      cur_tag, "header fields",
                      {hdr_hadd, hdr_padd, hdr_bind_restart, hdr_long_en, hdr_hail, hdr_poll_req},
                      (e_hadd << 8) | (e_padd << 4) | (e_bind << 3) | (e_len << 2) | (e_hail << 1) | e_poll);
            if (e_done && done_valid)
                check(int'(done_ok) == e_ok && int'(done_reason) == e_rsn, cur_tag,
                      "verdict {ok,reason}", {done_ok, done_reason}, (e_ok << 3) | e_rsn);
            if (pay_valid) mon_pay++;
            if (hdr_valid) begin
                mon_hdr++;
                mon_poll = hdr_poll_req; mon_bind = hdr_bind_restart;
                mon_len = hdr_long_en; mon_hail = hdr_hail;
            end
            if (done_valid) begin mon_done++; mon_rsn = done_reason; mon_ok = done_ok; end
        end
    end

    task automatic drive(input bit v, input bit s, input bit e, input bit l, input logic [7:0] dt);
        @(negedge clk);
        in_valid = v; in_sop = s; in_eop = e; in_long = l; in_data = dt;
    endtask

    task automatic clear_mon();
        mon_done = 0; mon_rsn = -1; mon_ok = -1; mon_pay = 0; mon_hdr = 0;
    endtask

    task automatic finish_frame();
        drive(0, 0, 0, 0, 8'h00);
        repeat (2) @(negedge clk);
        #1;
    endtask

    // Sends a frame and checks its verdict and forwarded count from the requirements
    task automatic send(input logic [7:0] h, input logic [7:0] b1, input int npay,
                        input bit lng, input int exp_rsn, input string tag);
        int lim, exp_pay;
        cur_tag = tag;
        clear_mon();
        drive(1, 1, 0, lng, h);
        drive(1, 0, (npay == 0), 0, b1);
        for (int i = 0; i < npay; i++)
            drive(1, 0, (i == npay - 1), 0, 8'(i * 7 + 3));
        finish_frame();
        lim = lng ? 97 : 9;
        exp_pay = (exp_rsn == 0) ? npay : ((exp_rsn == 4) ? lim : 0);
        check(mon_done == 1 && mon_rsn == exp_rsn, tag, "frame reason", mon_rsn, exp_rsn);
        check(mon_pay == exp_pay, tag, "payload bytes forwarded", mon_pay, exp_pay);
        check(mon_hdr == (exp_rsn == 0 || exp_rsn == 4), tag, "header pulses", mon_hdr,
              (exp_rsn == 0 || exp_rsn == 4));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        #1;
        // R1: outputs quiet during and after reset
        check(!pay_valid && !hdr_valid && !done_valid, "R1", "strobes in reset",
              {pay_valid, hdr_valid, done_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(!pay_valid && !hdr_valid && !done_valid, "R1", "strobes after reset",
              {pay_valid, hdr_valid, done_valid}, 0);

        // Host side, own address 0x5A
        cfg_host_side = 1; cfg_own_hadd = 8'h5A; cfg_asleep = 0; cfg_long_allow = 0;
        send(8'h5A, 8'h43, 3, 0, 0, "R10");
        check(mon_poll == 1, "R11", "host-side poll request flag", mon_poll, 1);
        send(8'h5A, 8'h83, 2, 0, 1, "R2");
        send(8'h33, 8'h03, 2, 0, 2, "R3");
        send(8'h00, 8'h4F, 0, 0, 2, "R3");
        cfg_asleep = 1;
        send(8'h00, 8'h4F, 0, 0, 0, "R3");
        cfg_asleep = 0;
        send(8'h5A, 8'h13, 1, 0, 3, "R5");
        send(8'h5A, 8'h23, 1, 0, 3, "R5");
        send(8'h5A, 8'h03, 9, 0, 0, "R6");
        send(8'h5A, 8'h03, 10, 0, 4, "R6");
        send(8'h5A, 8'h03, 12, 0, 4, "R6");
        send(8'h5A, 8'h03, 2, 1, 5, "R7");
        cfg_long_allow = 1;
        send(8'h5A, 8'h03, 97, 1, 0, "R6");
        send(8'h5A, 8'h03, 98, 1, 4, "R6");
        cfg_long_allow = 0;

        // R8: one-byte frame
        cur_tag = "R8";
        clear_mon();
        drive(1, 1, 1, 0, 8'h5A);
        finish_frame();
        check(mon_done == 1 && mon_rsn == 6, "R8", "runt reason", mon_rsn, 6);

        // R9: overlapping faults
        send(8'h11, 8'h93, 1, 0, 1, "R9");
        send(8'h11, 8'h13, 1, 0, 2, "R9");
        send(8'h5A, 8'h13, 1, 1, 3, "R9");
        send(8'h5A, 8'h03, 20, 1, 5, "R9");

        // R12: stray bytes ignored, restart abandons a frame
        cur_tag = "R12";
        clear_mon();
        drive(1, 0, 0, 0, 8'h5A);
        drive(1, 0, 0, 0, 8'h03);
        drive(1, 0, 1, 0, 8'h77);
        finish_frame();
        check(mon_done == 0 && mon_pay == 0 && mon_hdr == 0, "R12", "stray byte activity",
              mon_done + mon_pay + mon_hdr, 0);
        clear_mon();
        drive(1, 1, 0, 0, 8'h5A);
        drive(1, 0, 0, 0, 8'h03);
        drive(1, 0, 0, 0, 8'hAA);
        drive(1, 1, 0, 0, 8'h5A);
        drive(1, 0, 0, 0, 8'h43);
        drive(1, 0, 1, 0, 8'hBB);
        finish_frame();
        check(mon_done == 1 && mon_rsn == 0, "R12", "verdicts after restart", mon_done, 1);
        check(mon_pay == 2, "R12", "payload bytes across restart", mon_pay, 2);

        // Peripheral side
        cfg_host_side = 0; cfg_own_hadd = 8'h5A; cfg_own_padd = 4'h3;
        cfg_enumerated = 1; cfg_bound = 1; cfg_long_allow = 1;
        send(8'h5A, 8'hE3, 4, 0, 0, "R4");
        check(mon_bind == 1 && mon_len == 1 && mon_hail == 0 && mon_poll == 0, "R11",
              "peripheral-side flags", {mon_bind[0], mon_len[0], mon_hail[0], mon_poll[0]}, 4'b1100);
        send(8'h5A, 8'h63, 1, 0, 1, "R2");
        send(8'h5A, 8'h84, 1, 0, 2, "R4");
        send(8'h5B, 8'h83, 1, 0, 2, "R4");
        send(8'h5A, 8'h90, 0, 0, 2, "R4");
        send(8'h5A, 8'h9F, 0, 0, 2, "R4");
        send(8'h5A, 8'hB3, 30, 1, 0, "R4");
        cfg_bound = 0;
        send(8'h5A, 8'h90, 0, 0, 0, "R4");
        check(mon_hail == 1, "R11", "hail flag", mon_hail, 1);
        send(8'h5A, 8'h83, 1, 0, 2, "R4");
        cfg_enumerated = 0;
        send(8'h77, 8'h9F, 2, 0, 0, "R4");
        send(8'h5A, 8'h90, 0, 0, 2, "R4");
        cfg_long_allow = 0;
        send(8'h77, 8'h9F, 2, 1, 5, "R7");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule